// File: doc/BRIEF.md
# Bidirectional Signed-Count Shift Unit

This block shifts or rotates one data word by a signed distance and registers the result. Each request carries the word, a two's-complement count, a three-bit operation code and a flag that says whether the word is to be treated as signed. The leftmost bit (index WIDTH-1) is the most significant bit in every operation. A request is taken when `in_valid` is high, and the result appears on the next clock edge together with `out_valid`.

Six operations are offered: logical left, logical right, arithmetic left, arithmetic right, rotate left and rotate right. A negative count turns each operation into its mirror image, shifted by the magnitude of the count. Only a signed arithmetic right shift copies the sign bit into the vacated positions. Non-rotating shifts by the word width or more saturate to the fill value. Rotates wrap the count modulo the width.

Top module: `bidir_shift_unit`

## Requirements
- R1: Operation code 0 (logical left) by n moves every bit n places toward the MSB end, discards the n top bits and fills the n low positions with zero.
- R2: Operation code 1 (logical right) by n moves every bit n places toward the LSB end and fills the n top positions with zero, whatever the signedness flag says.
- R3: Operation code 2 (arithmetic left) with a count of zero or more gives the same result as code 0, with the signedness flag high or low.
- R4: Operation code 3 (arithmetic right) fills the vacated top positions with a copy of the input MSB when `in_signed` is 1, and with zero when `in_signed` is 0, which makes it equal to code 1.
- R5: Operation codes 4 (rotate left) and 5 (rotate right) move bits circularly with no loss, and they use the count magnitude modulo WIDTH.
- R6: A negative count swaps code 0 with 1, code 2 with 3 and code 4 with 5, and applies the swapped operation by the magnitude of the count. Arithmetic right reached this way still follows R4.
- R7: A non-rotating operation whose count magnitude is WIDTH or more gives the fill value in every bit: the input MSB for a signed arithmetic right shift, and zero in all other cases.
- R8: A count of zero, or operation code 6 or 7, returns the input word unchanged.
- R9: `out_valid` is high in the cycle after a cycle in which `in_valid` was high, and low otherwise. `out_result` changes only after an accepted request and otherwise holds its value.
- R10: A synchronous reset clears `out_result` to zero and drives `out_valid` low on the next edge, even while `in_valid` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Request strobe |
| in_data | input | WIDTH | Word to shift |
| in_count | input | CNT_W | Signed shift distance (two's complement) |
| in_op | input | 3 | Operation code (0 LSL, 1 LSR, 2 ASL, 3 ASR, 4 ROL, 5 ROR, 6/7 pass) |
| in_signed | input | 1 | 1 treats the word as signed for arithmetic right shifts |
| out_valid | output | 1 | Result valid, one cycle after the request |
| out_result | output | WIDTH | Registered shifted word |

## Verification
Direction reversal and saturation can act on the same request: a negative count whose magnitude is WIDTH or more must first flip the operation and then flood the word with the flip's fill value. The bench provokes this with counts of -WIDTH and of the most negative count on signed and unsigned arithmetic left shifts of words whose MSB is set, and with a full sweep of every count against every operation code. Each result is judged against a per-bit source-index model that handles direction, wrap and fill on its own terms, without any barrel staging.

// File: rtl/shift_pkg.sv
package shift_pkg;

  typedef enum logic [2:0] {
    OP_LSL  = 3'd0,
    OP_LSR  = 3'd1,
    OP_ASL  = 3'd2,
    OP_ASR  = 3'd3,
    OP_ROL  = 3'd4,
    OP_ROR  = 3'd5,
    OP_PASS = 3'd6,
    OP_PAS2 = 3'd7
  } shift_op_e;

  // decoded control after count-sign folding
  typedef struct packed {
    logic go_left;
    logic rotate;
    logic arith;
    logic keep;
  } shift_ctrl_t;

  function automatic logic op_is_left(shift_op_e op);
    return (op == OP_LSL) || (op == OP_ASL) || (op == OP_ROL);
  endfunction

  function automatic logic op_is_rotate(shift_op_e op);
    return (op == OP_ROL) || (op == OP_ROR);
  endfunction

  function automatic logic op_is_arith(shift_op_e op);
    return (op == OP_ASL) || (op == OP_ASR);
  endfunction

  function automatic logic op_is_pass(shift_op_e op);
    return (op == OP_PASS) || (op == OP_PAS2);
  endfunction

endpackage

// File: rtl/shift_count_norm.sv
module shift_count_norm
  import shift_pkg::*;
#(
  parameter int WIDTH = 16,
  parameter int CNT_W = 6
) (
  input  shift_op_e                 op,
  input  logic signed [CNT_W-1:0]   count,
  input  logic                      sign_mode,
  input  logic                      msb,
  output shift_ctrl_t               ctrl,
  output logic [$clog2(WIDTH)-1:0]  amt,
  output logic                      saturate,
  output logic                      fill_bit
);
  localparam int SH_W = $clog2(WIDTH);

  initial begin
    assert (CNT_W > SH_W && WIDTH >= 2)
      else $error("shift_count_norm: CNT_W must exceed log2(WIDTH)");
  end

  // magnitude of a two's-complement count; the most negative value maps
  // to 2**(CNT_W-1), which still fits as an unsigned CNT_W-bit number
  function automatic logic [CNT_W-1:0] count_mag(logic [CNT_W-1:0] c);
    return c[CNT_W-1] ? (~c + 1'b1) : c;
  endfunction

  function automatic logic [SH_W-1:0] wrap_amt(logic [CNT_W-1:0] m);
    int unsigned r;
    r = 32'(m) % WIDTH;
    return r[SH_W-1:0];
  endfunction

  logic             neg;
  logic [CNT_W-1:0] mag;
  logic             too_far;

  assign neg     = count[CNT_W-1];
  assign mag     = count_mag(count);
  assign too_far = 32'(mag) >= WIDTH;

  always_comb begin
    ctrl.go_left = op_is_left(op) ^ neg;
    ctrl.rotate  = op_is_rotate(op);
    ctrl.arith   = op_is_arith(op);
    ctrl.keep    = op_is_pass(op);
  end

  assign saturate = too_far && !ctrl.rotate && !ctrl.keep;
  assign amt      = ctrl.rotate ? wrap_amt(mag) : mag[SH_W-1:0];
  assign fill_bit = !ctrl.go_left && ctrl.arith && sign_mode && msb;

endmodule

// File: rtl/shift_barrel.sv
module shift_barrel #(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH-1:0]          din,
  input  logic                      go_left,
  input  logic                      rotate,
  input  logic                      fill,
  input  logic [$clog2(WIDTH)-1:0]  amt,
  output logic [WIDTH-1:0]          dout
);
  localparam int SH_W = $clog2(WIDTH);
  localparam logic [WIDTH-1:0] ONES = {WIDTH{1'b1}};

  logic [WIDTH-1:0] stage [SH_W+1];

  assign stage[0] = din;

  // one stage per count bit, each moving by a power of two
  for (genvar k = 0; k < SH_W; k++) begin : g_stage
    localparam int S = 1 << k;
    logic [WIDTH-1:0] lmove;
    logic [WIDTH-1:0] rmove;
    assign lmove = (stage[k] << S) | (rotate ? (stage[k] >> (WIDTH - S)) : '0);
    assign rmove = (stage[k] >> S) |
                   (rotate ? (stage[k] << (WIDTH - S)) : (fill ? ~(ONES >> S) : '0));
    assign stage[k+1] = !amt[k] ? stage[k] : (go_left ? lmove : rmove);
  end

  assign dout = stage[SH_W];

endmodule

// File: rtl/shift_out_reg.sv
module shift_out_reg #(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             take,
  input  logic [WIDTH-1:0] d,
  output logic             q_valid,
  output logic [WIDTH-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      q_valid <= 1'b0;
      q       <= '0;
    end else begin
      q_valid <= take;
      if (take) q <= d;
    end
  end

  assert_valid_follows_R9: assert property (@(posedge clk) disable iff (rst)
    take |=> q_valid);

  assert_idle_no_valid_R9: assert property (@(posedge clk) disable iff (rst)
    !take |=> !q_valid);

  assert_hold_when_idle_R9: assert property (@(posedge clk) disable iff (rst)
    !take |=> $stable(q));

  assert_reset_clears_R10: assert property (@(posedge clk)
    rst |=> (!q_valid && q == '0));

endmodule

// File: rtl/bidir_shift_unit.sv
module bidir_shift_unit
  import shift_pkg::*;
#(
  parameter int WIDTH = 16,
  parameter int CNT_W = 6
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     in_valid,
  input  logic [WIDTH-1:0]         in_data,
  input  logic signed [CNT_W-1:0]  in_count,
  input  logic [2:0]               in_op,
  input  logic                     in_signed,
  output logic                     out_valid,
  output logic [WIDTH-1:0]         out_result
);
  localparam int SH_W = $clog2(WIDTH);

  shift_op_e        op;
  shift_ctrl_t      ctrl;
  logic [SH_W-1:0]  amt;
  logic             saturate;
  logic             fill_bit;
  logic [WIDTH-1:0] barrel_out;
  logic [WIDTH-1:0] next_result;

  assign op = shift_op_e'(in_op);

  shift_count_norm #(.WIDTH(WIDTH), .CNT_W(CNT_W)) u_norm (
    .op        (op),
    .count     (in_count),
    .sign_mode (in_signed),
    .msb       (in_data[WIDTH-1]),
    .ctrl      (ctrl),
    .amt       (amt),
    .saturate  (saturate),
    .fill_bit  (fill_bit)
  );

  shift_barrel #(.WIDTH(WIDTH)) u_barrel (
    .din     (in_data),
    .go_left (ctrl.go_left),
    .rotate  (ctrl.rotate),
    .fill    (fill_bit),
    .amt     (amt),
    .dout    (barrel_out)
  );

  always_comb begin
    if (ctrl.keep)     next_result = in_data;
    else if (saturate) next_result = {WIDTH{fill_bit}};
    else               next_result = barrel_out;
  end

  shift_out_reg #(.WIDTH(WIDTH)) u_out (
    .clk     (clk),
    .rst     (rst),
    .take    (in_valid),
    .d       (next_result),
    .q_valid (out_valid),
    .q       (out_result)
  );

  // pass-through for zero count or spare codes
  assert_zero_count_keeps_R8: assert property (@(posedge clk) disable iff (rst)
    (in_valid && (in_count == '0 || in_op[2:1] == 2'b11)) |=> out_result == $past(in_data));

  // rotates conserve the number of set bits
  assert_rotate_lossless_R5: assert property (@(posedge clk) disable iff (rst)
    (in_valid && ctrl.rotate) |=> $countones(out_result) == $countones($past(in_data)));

  // signed arithmetic right with MSB set keeps the top bit set
  assert_sign_replicated_R4: assert property (@(posedge clk) disable iff (rst)
    (in_valid && fill_bit) |=> out_result[WIDTH-1]);

  // positive logical right leaves a zero at the top
  assert_lsr_zero_top_R2: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op == OP_LSR && in_count > 0) |=> !out_result[WIDTH-1]);

  // saturated shifts flood the word with the fill value
  assert_saturate_fill_R7: assert property (@(posedge clk) disable iff (rst)
    (in_valid && saturate) |=> out_result == {WIDTH{$past(fill_bit)}});

endmodule

// File: tb/bidir_shift_unit_test.sv
module bidir_shift_unit_test;
  localparam int W  = 16;
  localparam int CW = 6;

  logic                  clk = 1'b0;
  logic                  rst;
  logic                  in_valid;
  logic [W-1:0]          in_data;
  logic signed [CW-1:0]  in_count;
  logic [2:0]            in_op;
  logic                  in_signed;
  logic                  out_valid;
  logic [W-1:0]          out_result;

  int checks   = 0;
  int failures = 0;
  int cycles   = 0;
  bit done     = 0;

  logic [W-1:0] exp_q[$];
  string        tag_q[$];
  logic [W-1:0] last_exp;

  always #5 clk = ~clk;

  bidir_shift_unit #(.WIDTH(W), .CNT_W(CW)) uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
    .in_count(in_count), .in_op(in_op), .in_signed(in_signed),
    .out_valid(out_valid), .out_result(out_result)
  );

  // per-bit source-index model
  function automatic logic [W-1:0] model(logic [W-1:0] d, int cnt, int op, bit sgn);
    logic [W-1:0] r;
    bit left, rot, fb;
    int n, src;
    if (op > 5) return d;
    left = (op == 0 || op == 2 || op == 4);
    n = cnt;
    if (n < 0) begin left = !left; n = -n; end
    rot = (op >= 4);
    fb  = (!left && (op == 2 || op == 3) && sgn) ? d[W-1] : 1'b0;
    for (int i = 0; i < W; i++) begin
      if (rot) begin
        src = left ? i - n : i + n;
        src = ((src % W) + W) % W;
        r[i] = d[src];
      end else if (left) begin
        r[i] = (i - n >= 0) ? d[i - n] : 1'b0;
      end else begin
        r[i] = (i + n < W) ? d[i + n] : fb;
      end
    end
    return r;
  endfunction

  task automatic check(string tag, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  task automatic drive(logic [W-1:0] d, int cnt, int op, bit sgn, string tag);
    @(negedge clk);
    in_valid  = 1'b1;
    in_data   = d;
    in_count  = CW'(cnt);
    in_op     = 3'(op);
    in_signed = sgn;
    exp_q.push_back(model(d, cnt, op, sgn));
    tag_q.push_back(tag);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
    end
  endtask

  // monitor: pops the scoreboard when a result appears
  always @(negedge clk) begin
    if (!rst && out_valid) begin
      if (exp_q.size() == 0) begin
        checks++; failures++;
        $display("FAIL R9 actual=unexpected_valid expected=no_valid");
      end else begin
        last_exp = exp_q.pop_front();
        check(tag_q.pop_front(), out_result, last_exp);
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      done = 1;
      checks++; failures++;
      $display("FAIL watchdog actual=%0d expected=<100000", cycles);
      finish_run();
    end
  end

  initial begin
    rst = 1'b1; in_valid = 1'b0; in_data = '0; in_count = '0;
    in_op = '0; in_signed = 1'b0;
    repeat (3) @(negedge clk);
    check("R10 reset result", out_result, '0);
    check("R10 reset valid", W'(out_valid), '0);
    rst = 1'b0;

    drive(16'h8001, 1, 0, 0, "R1 lsl1");
    drive(16'hABCD, 4, 0, 1, "R1 lsl4");
    drive(16'h8001, 1, 1, 1, "R2 lsr1 signed");
    drive(16'hF0F0, 5, 1, 0, "R2 lsr5");
    drive(16'hC3A5, 3, 2, 1, "R3 asl signed");
    drive(16'hC3A5, 3, 2, 0, "R3 asl unsigned");
    drive(16'h8000, 3, 3, 1, "R4 asr signed");
    drive(16'h8000, 3, 3, 0, "R4 asr unsigned");
    drive(16'h7FF0, 2, 3, 1, "R4 asr positive");
    drive(16'h8001, 1, 4, 0, "R5 rol1");
    drive(16'h8001, 17, 4, 0, "R5 rol17 wraps");
    drive(16'h1234, 31, 5, 1, "R5 ror31");
    drive(16'h1234, 16, 5, 0, "R5 ror16");
    drive(16'h00F0, -3, 0, 0, "R6 lsl neg");
    drive(16'h00F0, -3, 1, 0, "R6 lsr neg");
    drive(16'h8000, -1, 2, 1, "R6 asl neg signed");
    drive(16'h8000, -1, 2, 0, "R6 asl neg unsigned");
    drive(16'h8001, -2, 3, 1, "R6 asr neg");
    drive(16'h8001, -1, 4, 0, "R6 rol neg");
    drive(16'h8001, -1, 5, 0, "R6 ror neg");
    drive(16'hFFFF, 16, 0, 1, "R7 lsl16");
    drive(16'h8000, 20, 3, 1, "R7 asr signed far");
    drive(16'h8001, -32, 2, 1, "R7 asl most negative signed");
    drive(16'h8001, -16, 2, 0, "R7 asl neg unsigned");
    drive(16'h8001, -16, 3, 1, "R7 asr neg far");
    drive(16'hBEEF, 0, 3, 1, "R8 zero count");
    drive(16'hBEEF, 9, 6, 1, "R8 code6");
    drive(16'hBEEF, -9, 7, 0, "R8 code7");
    idle(3);

    // R9: valid dropped, result held
    check("R9 valid low when idle", W'(out_valid), '0);
    check("R9 result held", out_result, last_exp);

    // sweep of all counts and codes
    for (int op = 0; op < 8; op++)
      for (int c = -32; c < 32; c++) begin
        drive(16'h8B1D, c, op, 1, "R6 sweep signed");
        drive(16'h8B1D, c, op, 0, "R6 sweep unsigned");
        drive(16'h4C63, c, op, 1, "R5 sweep positive");
      end
    idle(3);

    // R10: reset wins over a request
    @(negedge clk);
    rst = 1'b1; in_valid = 1'b1; in_data = 16'hFFFF; in_count = 6'sd1; in_op = 3'd1;
    @(negedge clk);
    check("R10 reset clears result", out_result, '0);
    check("R10 reset clears valid", W'(out_valid), '0);
    rst = 1'b0; in_valid = 1'b0;
    idle(2);
    check("R9 no valid after reset", W'(out_valid), '0);
    if (exp_q.size() != 0) begin
      checks++; failures++;
      $display("FAIL R9 actual=%0d expected=0 pending results", exp_q.size());
    end
    done = 1;
    finish_run();
  end

endmodule